// File: doc/BRIEF.md
# Audio Clock Ratio and Mode Controller

This block sits in the master-clock domain of an audio converter front end and decides how the datapath runs. It measures how many master-clock cycles fit into one frame-clock period and turns that count into a ratio code. From the ratio, or from a two-bit field when automatic setting is off, it derives the sampling-speed class. It also resolves whether the serial input carries PCM or DSD data. A dedicated pin can force DSD. Otherwise a register bit chooses the format.

A single run flag gates the downstream filters and modulators. The flag is low whenever a clock is absent, the measured ratio is not one the block recognises, or the effective mode (format, speed class, ratio) has just changed. A frame clock or bit clock that stays silent is caught by counters in the master-clock domain. A stopped master clock is caught by a watchdog clocked from a free-running reference. After any disturbance, the flag returns only after the mode has been stable for several whole frame periods.

Top module: `audio_clk_mode_ctrl`

## Requirements
- R1: After reset is released, `dp_run_o` stays 0 and `ratio_o` stays 0 while the master clock is absent, and both stay so until valid frames have been measured.
- R2: The measured period (master-clock cycles between frame-clock rising edges) maps to a ratio code. Nominal 128 maps to 1, 192 to 2, 256 to 3, 384 to 4, 512 to 5 and 768 to 6, each accepted within plus or minus 2 cycles. Any other period yields code 0 (invalid).
- R3: `ratio_o` takes a new value only after two consecutive frames have measured the same code. Frames whose periods alternate between two values never replace the code currently held.
- R4: Speed-class encoding is 00 normal, 01 double and 10 quad. With `ratio_auto_i`=1, codes 1 and 2 give 01 and codes 3 to 6 give 00, and `speed_sel_i` is ignored.
- R5: With `ratio_auto_i`=0, `speed_o` equals `speed_sel_i`, and the value 11 is treated as 00.
- R6: `dsd_o` is 1 when `dsd_pin_i` is 1. Otherwise `dsd_o` equals `dsd_sel_i`. A register toggle that leaves the effective format unchanged does not disturb `dp_run_o`.
- R7: Any change of the effective mode {format, speed class, ratio code} drives `dp_run_o` to 0 on the next cycle. The flag rises again only after 4 complete frame periods with stable mode and healthy clocks.
- R8: If the frame clock or the bit clock shows no edge for 2048 master-clock cycles, `ratio_o` becomes 0 and `dp_run_o` becomes 0. Normal operation resumes after the clock returns and the frames requalify.
- R9: If the master clock stops, `dp_run_o` falls within a bounded number of reference-clock cycles. After the master clock restarts, the flag stays 0 until the frames requalify.
- R10: While the held ratio code is 0, `dp_run_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk_i | input | 1 | Master clock; clocks all measurement and mode logic |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ref_clk_i | input | 1 | Free-running reference clock for the master-clock watchdog |
| frame_clk_i | input | 1 | Frame (sample-rate) clock, asynchronous |
| bit_clk_i | input | 1 | Serial bit clock, asynchronous, monitored for activity |
| dsd_pin_i | input | 1 | Pin forcing DSD input format when high |
| dsd_sel_i | input | 1 | Register bit: 0 PCM, 1 DSD, used when the pin is low |
| ratio_auto_i | input | 1 | Register bit: 1 automatic ratio/speed setting, 0 manual |
| speed_sel_i | input | 2 | Manual speed-class field |
| speed_o | output | 2 | Effective speed class |
| ratio_o | output | 3 | Held master-clock ratio code |
| dsd_o | output | 1 | Effective format, 1 = DSD |
| dp_run_o | output | 1 | Datapath run flag, 0 holds the datapath in reset |

## Verification
The hardest state to reach from the ports is a master-clock stall. The measuring logic freezes with stale state and can only be overridden by the reference-domain watchdog. The bench gates its master-clock generator while the reference clock keeps running. It samples the run flag on time rather than on clock edges, then restarts the clock and waits for requalification. A second awkward case is a frame period that never settles. The bench's frame generator can alternate between two lengths, and it enters that pattern from a cleared state so that no code is ever adopted.

// File: rtl/acm_pkg.sv
package acm_pkg;
  localparam logic [2:0] RATIO_NONE = 3'd0;
  localparam int         NUM_RATIOS = 6;
  localparam int         NOM_RATIO [NUM_RATIOS] = '{128, 192, 256, 384, 512, 768};

  localparam logic [1:0] SPD_NORMAL = 2'd0;
  localparam logic [1:0] SPD_DOUBLE = 2'd1;

  typedef struct packed {
    logic       dsd;
    logic [1:0] speed;
    logic [2:0] ratio;
  } mode_t;

  function automatic logic [2:0] classify_period(input int period, input int tol);
    logic [2:0] code;
    code = RATIO_NONE;
    for (int i = 0; i < NUM_RATIOS; i++) begin
      if (period >= NOM_RATIO[i] - tol && period <= NOM_RATIO[i] + tol)
        code = 3'(i + 1);
    end
    return code;
  endfunction
endpackage

// File: rtl/acm_sync.sv
module acm_sync #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/acm_mclk_watchdog.sv
module acm_mclk_watchdog #(
  parameter int WD_LIMIT = 16
) (
  input  logic ref_clk_i,
  input  logic rst_ni,
  input  logic mclk_tgl_i,
  output logic mclk_ok_o
);
  localparam int WW = $clog2(WD_LIMIT + 1);

  logic          tgl_s, tgl_d;
  logic [WW-1:0] idle_q;
  logic          ok_q;
  logic          seen;

  acm_sync #(.W(1)) u_tgl_sync (
    .clk_i (ref_clk_i),
    .rst_ni(rst_ni),
    .d_i   (mclk_tgl_i),
    .q_o   (tgl_s)
  );

  assign seen = tgl_s ^ tgl_d;

  always_ff @(posedge ref_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tgl_d  <= 1'b0;
      idle_q <= '0;
      ok_q   <= 1'b0;
    end else begin
      tgl_d <= tgl_s;
      if (seen) begin
        idle_q <= '0;
        ok_q   <= 1'b1;
      end else if (idle_q == WW'(WD_LIMIT - 1)) begin
        ok_q <= 1'b0;
      end else begin
        idle_q <= idle_q + 1'b1;
      end
    end
  end

  assign mclk_ok_o = ok_q;

  a_r9_ok_needs_activity: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    $rose(mclk_ok_o) |-> $past(seen));
  a_r9_idle_drops_ok: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    (idle_q == WW'(WD_LIMIT - 1) && !seen) |=> !mclk_ok_o);
endmodule

// File: rtl/acm_frame_meter.sv
module acm_frame_meter import acm_pkg::*; #(
  parameter int LOSS_LIMIT = 2048,
  parameter int RATIO_TOL  = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       frame_s_i,
  input  logic       bit_s_i,
  input  logic       mclk_ok_s_i,
  output logic       frame_rise_o,
  output logic [2:0] ratio_o,
  output logic       clocks_ok_o
);
  localparam int CW = $clog2(LOSS_LIMIT + 1);

  logic          frame_d, bit_d;
  logic [CW-1:0] fcnt_q, bcnt_q;
  logic          have_rise_q, last_vld_q;
  logic [2:0]    last_meas_q, ratio_q, meas;
  logic          rise, bedge, flost, blost;

  assign rise  = frame_s_i & ~frame_d;
  assign bedge = bit_s_i ^ bit_d;
  assign flost = fcnt_q >= CW'(LOSS_LIMIT);
  assign blost = bcnt_q >= CW'(LOSS_LIMIT);
  assign meas  = classify_period(int'(fcnt_q) + 1, RATIO_TOL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_d     <= 1'b0;
      bit_d       <= 1'b0;
      fcnt_q      <= '0;
      bcnt_q      <= '0;
      have_rise_q <= 1'b0;
      last_vld_q  <= 1'b0;
      last_meas_q <= RATIO_NONE;
      ratio_q     <= RATIO_NONE;
    end else begin
      frame_d <= frame_s_i;
      bit_d   <= bit_s_i;
      if (bedge)       bcnt_q <= '0;
      else if (!blost) bcnt_q <= bcnt_q + 1'b1;
      if (rise)        fcnt_q <= '0;
      else if (!flost) fcnt_q <= fcnt_q + 1'b1;

      if (!mclk_ok_s_i || flost || blost) begin
        have_rise_q <= 1'b0;
        last_vld_q  <= 1'b0;
        ratio_q     <= RATIO_NONE;
      end else if (rise) begin
        have_rise_q <= 1'b1;
        if (have_rise_q) begin
          last_meas_q <= meas;
          last_vld_q  <= 1'b1;
          // adopt only when two consecutive frames agree
          if (last_vld_q && meas == last_meas_q) ratio_q <= meas;
        end
      end
    end
  end

  assign frame_rise_o = rise;
  assign ratio_o      = ratio_q;
  assign clocks_ok_o  = mclk_ok_s_i && !flost && !blost && (ratio_q != RATIO_NONE);

  a_r3_adopt_on_frame_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ratio_q != $past(ratio_q) && ratio_q != RATIO_NONE) |-> $past(rise));
  a_r8_loss_clears_ratio: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flost || blost) |=> (ratio_o == RATIO_NONE));
endmodule

// File: rtl/acm_mode_ctrl.sv
module acm_mode_ctrl import acm_pkg::*; #(
  parameter int HOLD_FRAMES = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       frame_rise_i,
  input  logic       clocks_ok_i,
  input  logic [2:0] ratio_i,
  input  logic       ratio_auto_i,
  input  logic [1:0] speed_sel_i,
  input  logic       dsd_pin_i,
  input  logic       dsd_sel_i,
  output mode_t      mode_o,
  output logic       run_o
);
  // first edge after a change opens the count, HOLD_FRAMES more close whole periods
  localparam int HOLD_EDGES = HOLD_FRAMES + 1;
  localparam int HW         = $clog2(HOLD_EDGES + 1);

  mode_t         mode_now, mode_q;
  logic [HW-1:0] hold_q;
  logic          changed;

  always_comb begin
    mode_now.dsd   = dsd_pin_i | dsd_sel_i;
    mode_now.ratio = ratio_i;
    if (ratio_auto_i)
      mode_now.speed = (ratio_i == 3'd1 || ratio_i == 3'd2) ? SPD_DOUBLE : SPD_NORMAL;
    else
      mode_now.speed = (speed_sel_i == 2'b11) ? SPD_NORMAL : speed_sel_i;
  end

  assign changed = mode_now != mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      hold_q <= '0;
    end else begin
      mode_q <= mode_now;
      if (!clocks_ok_i || changed)
        hold_q <= '0;
      else if (frame_rise_i && hold_q != HW'(HOLD_EDGES))
        hold_q <= hold_q + 1'b1;
    end
  end

  assign mode_o = mode_q;
  assign run_o  = (hold_q == HW'(HOLD_EDGES));

  a_r7_change_stops_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q != $past(mode_q)) |-> !run_o);
  a_r7_run_rises_on_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_o) |-> $past(frame_rise_i));
  a_r6_pin_forces_dsd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dsd_pin_i |=> mode_o.dsd);
  a_r10_no_ratio_no_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ratio_i == RATIO_NONE) |=> !run_o);
endmodule

// File: rtl/audio_clk_mode_ctrl.sv
module audio_clk_mode_ctrl import acm_pkg::*; #(
  parameter int LOSS_LIMIT  = 2048,
  parameter int RATIO_TOL   = 2,
  parameter int HOLD_FRAMES = 4,
  parameter int WD_LIMIT    = 16,
  parameter int TGL_BIT     = 3
) (
  input  logic       mclk_i,
  input  logic       rst_ni,
  input  logic       ref_clk_i,
  input  logic       frame_clk_i,
  input  logic       bit_clk_i,
  input  logic       dsd_pin_i,
  input  logic       dsd_sel_i,
  input  logic       ratio_auto_i,
  input  logic [1:0] speed_sel_i,
  output logic [1:0] speed_o,
  output logic [2:0] ratio_o,
  output logic       dsd_o,
  output logic       dp_run_o
);
  logic [TGL_BIT:0] div_q;
  logic [1:0]       clk_s;
  logic             mclk_ok_ref, mclk_ok_s;
  logic             frame_rise, clocks_ok, run;
  logic [2:0]       ratio;
  mode_t            mode;

  always_ff @(posedge mclk_i or negedge rst_ni) begin
    if (!rst_ni) div_q <= '0;
    else         div_q <= div_q + 1'b1;
  end

  acm_mclk_watchdog #(.WD_LIMIT(WD_LIMIT)) u_wd (
    .ref_clk_i (ref_clk_i),
    .rst_ni    (rst_ni),
    .mclk_tgl_i(div_q[TGL_BIT]),
    .mclk_ok_o (mclk_ok_ref)
  );

  acm_sync #(.W(2)) u_clk_sync (
    .clk_i (mclk_i),
    .rst_ni(rst_ni),
    .d_i   ({bit_clk_i, frame_clk_i}),
    .q_o   (clk_s)
  );

  acm_sync #(.W(1)) u_ok_sync (
    .clk_i (mclk_i),
    .rst_ni(rst_ni),
    .d_i   (mclk_ok_ref),
    .q_o   (mclk_ok_s)
  );

  acm_frame_meter #(.LOSS_LIMIT(LOSS_LIMIT), .RATIO_TOL(RATIO_TOL)) u_meter (
    .clk_i       (mclk_i),
    .rst_ni      (rst_ni),
    .frame_s_i   (clk_s[0]),
    .bit_s_i     (clk_s[1]),
    .mclk_ok_s_i (mclk_ok_s),
    .frame_rise_o(frame_rise),
    .ratio_o     (ratio),
    .clocks_ok_o (clocks_ok)
  );

  acm_mode_ctrl #(.HOLD_FRAMES(HOLD_FRAMES)) u_mode (
    .clk_i       (mclk_i),
    .rst_ni      (rst_ni),
    .frame_rise_i(frame_rise),
    .clocks_ok_i (clocks_ok),
    .ratio_i     (ratio),
    .ratio_auto_i(ratio_auto_i),
    .speed_sel_i (speed_sel_i),
    .dsd_pin_i   (dsd_pin_i),
    .dsd_sel_i   (dsd_sel_i),
    .mode_o      (mode),
    .run_o       (run)
  );

  // a stalled master clock freezes the flag register, so gate it from the reference side
  assign dp_run_o = run & mclk_ok_ref;
  assign speed_o  = mode.speed;
  assign ratio_o  = mode.ratio;
  assign dsd_o    = mode.dsd;
endmodule

// File: tb/audio_clk_mode_ctrl_tb_top.sv
module audio_clk_mode_ctrl_tb_top;
  logic       mclk = 1'b0, ref_clk = 1'b0, rst_n = 1'b0;
  logic       frame_clk = 1'b0, bit_clk = 1'b0;
  logic       dsd_pin = 1'b0, dsd_sel = 1'b0, ratio_auto = 1'b1;
  logic [1:0] speed_sel = 2'b00;
  logic [1:0] speed;
  logic [2:0] ratio;
  logic       dsd, dp_run;

  bit mclk_en = 1'b0, fr_en = 1'b1, bk_en = 1'b1, alt_en = 1'b0, alt_ph = 1'b0;
  int flen = 256, alt_len = 512, gcnt = 0, bkc = 0;
  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #5 mclk = mclk_en ? ~mclk : mclk;
  always #12 ref_clk = ~ref_clk;

  audio_clk_mode_ctrl dut_i (
    .mclk_i      (mclk),
    .rst_ni      (rst_n),
    .ref_clk_i   (ref_clk),
    .frame_clk_i (frame_clk),
    .bit_clk_i   (bit_clk),
    .dsd_pin_i   (dsd_pin),
    .dsd_sel_i   (dsd_sel),
    .ratio_auto_i(ratio_auto),
    .speed_sel_i (speed_sel),
    .speed_o     (speed),
    .ratio_o     (ratio),
    .dsd_o       (dsd),
    .dp_run_o    (dp_run)
  );

  // frame and bit clock generator, master-clock synchronous, updated off the active edge
  always @(negedge mclk) begin
    int cur;
    cur = (alt_en && alt_ph) ? alt_len : flen;
    if (gcnt >= cur - 1) begin
      gcnt   = 0;
      alt_ph = ~alt_ph;
    end else gcnt++;
    if (fr_en) frame_clk = (gcnt < cur / 2);
    if (bk_en) begin
      bkc++;
      if (bkc == 2) begin bkc = 0; bit_clk = ~bit_clk; end
    end
  end

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge mclk);
  endtask

  task automatic frames(int n);
    cyc(n * flen);
  endtask

  task automatic t_reset_no_mclk;
    #20 rst_n = 1'b1;
    #2000;
    chk("R1 run low without mclk", dp_run, 0);
    chk("R1 ratio none without mclk", ratio, 0);
    mclk_en = 1'b1;
    cyc(8);
    chk("R1 run low before frames qualify", dp_run, 0);
  endtask

  task automatic t_auto_ratio(int len, int code, int spd, string req);
    flen = len;
    frames(12);
    chk({req, " ratio code"}, ratio, code);
    chk({"R4 speed for ", req}, speed, spd);
    chk({"R7 run after settle ", req}, dp_run, 1);
  endtask

  task automatic t_ratio_change;
    flen = 512;
    frames(4);
    chk("R7 run dropped on ratio change", dp_run, 0);
    frames(8);
    chk("R2 ratio 512", ratio, 5);
    chk("R7 run back after 512 settles", dp_run, 1);
  endtask

  task automatic t_tolerance;
    flen = 256; frames(12);
    flen = 258; frames(12);
    chk("R2 258 within tolerance", ratio, 3);
    chk("R2 run kept at 258", dp_run, 1);
    flen = 254; frames(12);
    chk("R2 254 within tolerance", ratio, 3);
    flen = 259; frames(12);
    chk("R2 259 invalid", ratio, 0);
    chk("R10 run low on invalid ratio", dp_run, 0);
    flen = 253; frames(12);
    chk("R2 253 invalid", ratio, 0);
    flen = 256; frames(12);
    chk("R2 recover to 256", ratio, 3);
  endtask

  task automatic t_bit_loss;
    bk_en = 1'b0;
    cyc(2200);
    chk("R8 bit clock loss ratio", ratio, 0);
    chk("R8 bit clock loss run", dp_run, 0);
    bk_en = 1'b1;
    frames(12);
    chk("R8 bit clock recovery", dp_run, 1);
  endtask

  task automatic t_frame_loss_and_alt;
    fr_en = 1'b0;
    cyc(2200);
    chk("R8 frame clock loss ratio", ratio, 0);
    chk("R8 frame clock loss run", dp_run, 0);
    alt_en = 1'b1;
    fr_en  = 1'b1;
    frames(16);
    chk("R3 alternating periods never adopted", ratio, 0);
    chk("R3 run low with alternating periods", dp_run, 0);
    alt_en = 1'b0;
    frames(12);
    chk("R3 steady periods adopted", ratio, 3);
    chk("R8 frame clock recovery run", dp_run, 1);
  endtask

  task automatic t_mclk_stop;
    #3;
    mclk_en = 1'b0;
    #1000;
    chk("R9 run low while mclk stopped", dp_run, 0);
    mclk_en = 1'b1;
    cyc(20);
    chk("R9 run low right after restart", dp_run, 0);
    frames(12);
    chk("R9 run back after requalify", dp_run, 1);
  endtask

  task automatic t_format;
    dsd_sel = 1'b1;
    cyc(4);
    chk("R6 reg selects dsd", dsd, 1);
    chk("R7 run dropped on format change", dp_run, 0);
    frames(8);
    chk("R7 run back after format change", dp_run, 1);
    dsd_pin = 1'b1;
    cyc(4);
    dsd_sel = 1'b0;
    cyc(4);
    chk("R6 pin holds dsd with reg 0", dsd, 1);
    chk("R6 no reset when effective format kept", dp_run, 1);
    dsd_pin = 1'b0;
    cyc(4);
    chk("R6 pcm when pin and reg low", dsd, 0);
    frames(8);
  endtask

  task automatic t_manual;
    ratio_auto = 1'b0; speed_sel = 2'b01;
    cyc(4);
    chk("R5 manual double", speed, 1);
    chk("R7 run dropped on speed change", dp_run, 0);
    frames(8);
    chk("R7 run back after speed change", dp_run, 1);
    speed_sel = 2'b10; cyc(4);
    chk("R5 manual quad", speed, 2);
    speed_sel = 2'b11; cyc(4);
    chk("R5 reserved field as normal", speed, 0);
    speed_sel = 2'b10; ratio_auto = 1'b1; cyc(4);
    chk("R4 field ignored in auto", speed, 0);
    frames(8);
  endtask

  initial begin
    t_reset_no_mclk();
    t_auto_ratio(256, 3, 0, "R2 256");
    t_ratio_change();
    t_auto_ratio(768, 6, 0, "R2 768");
    t_auto_ratio(384, 4, 0, "R2 384");
    t_auto_ratio(128, 1, 1, "R2 128");
    t_auto_ratio(192, 2, 1, "R2 192");
    t_tolerance();
    t_bit_loss();
    t_frame_loss_and_alt();
    t_mclk_stop();
    t_format();
    t_manual();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        #1_500_000;
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule